// File: doc/BRIEF.md
# Sync Source Selection Matrix

This block produces the internal active-high sync strobes that a digital up-converter uses to start, reset or retime its functions. Each synchronized function has a small mode field that picks its source. The sources are two active-low external sync pins (A and B), a terminal-count pulse from a programmable internal sync counter, a software one-shot, constant off and constant on. The block contains the sync counter, the one-shot generator (held-level or single-cycle pulse) and a gain-hold register. The gain-hold register applies a new gain value either at once or on the next pin-B sync.

Configuration is written through a plain write port of address, data and enable. There is no read-back. Every strobe on `sync_out` is a combinational function of the configuration registers, the two pins, the one-shot state and the counter state, so a pin edge reaches the strobes in the same cycle. Strobe indices: 0 interpolation counter, 1 sync counter, 2 output sync, 3 diagnostics, 4 frequency, 5 phase, 6 NCO reset, 7 dither clear, 8 resampler serial clock, 9 controller serial clock, 10 resampler init, 11 resampler ratio, 12 and up flush channels 0..NUM_FLUSH-1.

Register map (byte-wide, two-bit fields packed from bit 0 upward unless noted):
- Address 0: bit0 selects one-shot for mode 2, bit1 selects level form (1) or pulse form (0), bit2 is the one-shot bit.
- Address 1: strobes 0..3.
- Address 2: strobes 4..7.
- Address 3: strobes 8 and 9 in bits [1:0] and [3:2]; bit4 is the gain-hold select.
- Address 4: strobe 10 in bits [2:0] and strobe 11 in bits [5:3], both three-bit fields.
- Address 5: flush channels.
- Address 6: counter period.
- Address 8: gain value.

Top module: `sync_matrix`

## Requirements
- R1: A two-bit mode of 0 holds the strobe low, 1 follows the function's external pin, and 3 holds the strobe high.
- R2: Both pins are active low. Strobes 4..7 take pin B for mode 1; all other two-bit strobes take pin A.
- R3: For strobes 0, 2, 3, 4..7 and the flush strobes, mode 2 gives the counter terminal count when address 0 bit0 is 0 and the one-shot when it is 1.
- R4: For the sync counter strobe (index 1), mode 2 always gives the one-shot, whatever address 0 bit0 holds.
- R5: For both serial-clock strobes (indices 8 and 9), mode 2 gives pin B.
- R6: The three-bit modes of strobes 10 and 11 decode as follows: 0, 1 and 5 are off, 2 is pin A, 3 is pin B, 4 is the one-shot, and 6 and 7 are on.
- R7: In pulse form, a write to address 0 with bit2 set asserts the one-shot for exactly the one cycle after the write edge.
- R8: In level form, the one-shot equals the stored bit2 and stays asserted until a write clears it.
- R9: The counter reloads to period P on the edge where its own strobe is high, or on the edge after it reaches zero. Its terminal count is high while it holds zero, which is P cycles after a reload, and it then repeats every P+1 cycles.
- R10: With the gain-hold select at 0, a gain write appears on `gain_out` after that edge. With the select at 1, `gain_out` keeps its value until an edge that sees pin B asserted, and then takes the last written gain.
- R11: Reset loads interpolation 1, counter 2, output 2, diagnostics 2, frequency 3, phase 3, NCO 0, dither 0, both serial clocks 1, resampler init 2 (three-bit), resampler ratio 3 (three-bit), every flush 1, gain-hold 0, one-shot controls 0, period 15 and gain 0.
- R12: Each flush channel has its own mode field (channel k in address 5 bits [2k+1:2k]) and pin A for mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_a_n | input | 1 | External sync pin A, active low |
| sync_b_n | input | 1 | External sync pin B, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration register address |
| wr_data | input | 8 | Configuration write data |
| sync_out | output | 12+NUM_FLUSH | Active-high internal sync strobes |
| gain_out | output | GAIN_W | Gain value currently applied |

## Verification
A wrong configuration bit or a wrong source-routing choice appears in the same cycle as a wrong level on one strobe, once the matching pin or one-shot combination is applied. For that reason the bench sweeps every mode of every strobe against all pin and one-shot combinations. A wrong counter state appears only as a terminal-count pulse in the wrong cycle, up to P+1 cycles after a reload, so the counter is checked cycle by cycle over two periods. A stuck gain-hold state appears as `gain_out` either changing before the pin-B edge or failing to change after it.

// File: rtl/sync_matrix_pkg.sv
package sync_matrix_pkg;
  localparam int REG_W   = 8;
  localparam int N_FIXED = 12;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_SER    = 4'd3;
  localparam logic [3:0] A_PERIOD = 4'd6;
  localparam logic [3:0] A_GAIN   = 4'd8;

  typedef enum logic [1:0] {ALT_TC, ALT_ONESHOT, ALT_PIN_B} alt_src_e;

  // strobes 4..7 follow pin B in mode 1
  function automatic logic on_pin_b(input int idx);
    return (idx >= 4) && (idx <= 7);
  endfunction

  function automatic alt_src_e alt_kind(input int idx);
    if (idx == 1) return ALT_ONESHOT;
    if (idx == 8 || idx == 9) return ALT_PIN_B;
    return ALT_TC;
  endfunction

  function automatic int fld_addr(input int idx);
    if (idx < 4)  return 1;
    if (idx < 8)  return 2;
    if (idx < 10) return 3;
    if (idx < 12) return 4;
    return 5;
  endfunction

  function automatic int fld_lsb(input int idx);
    if (idx < 10)  return 2 * (idx % 4);
    if (idx == 10) return 0;
    if (idx == 11) return 3;
    return 2 * (idx - 12);
  endfunction

  function automatic logic [REG_W-1:0] cfg_rst(input int a);
    case (a)
      1:       return 8'hA9;
      2:       return 8'h0F;
      3:       return 8'h05;
      4:       return 8'h1A;
      5:       return 8'h55;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sync_sel2.sv
module sync_sel2 (
  input  logic [1:0] mode,
  input  logic       pin,
  input  logic       alt,
  output logic       y
);
  always_comb begin
    unique case (mode)
      2'd0: y = 1'b0;
      2'd1: y = pin;
      2'd2: y = alt;
      default: y = 1'b1;
    endcase
  end
endmodule

// File: rtl/sync_sel3.sv
module sync_sel3 (
  input  logic [2:0] mode,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       os,
  output logic       y
);
  always_comb begin
    unique case (mode)
      3'd2: y = pin_a;
      3'd3: y = pin_b;
      3'd4: y = os;
      3'd6, 3'd7: y = 1'b1;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/sync_cnt.sv
module sync_cnt #(
  parameter int            W   = 8,
  parameter logic [W-1:0]  RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period,
  input  logic         sync,
  output logic         tc
);
  logic [W-1:0] cnt_q;

  assign tc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= RST;
    else if (sync || tc)   cnt_q <= period;
    else                   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/oneshot_gen.sv
module oneshot_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_level,
  input  logic wr_fire,
  input  logic hold_level,
  input  logic hold_bit,
  output logic os
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= wr_stb && wr_fire && !wr_level;
  end

  assign os = hold_level ? hold_bit : pulse_q;
endmodule

// File: rtl/gain_hold.sv
module gain_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         hold_mode,
  input  logic         sync,
  output logic [W-1:0] gain
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      gain   <= '0;
    end else if (wr) begin
      pend_q <= wdata;
      if (!hold_mode) gain <= wdata;
    end else if (hold_mode && sync) begin
      gain <= pend_q;
    end
  end
endmodule

// File: rtl/sync_matrix.sv
module sync_matrix
  import sync_matrix_pkg::*;
#(
  parameter int               NUM_FLUSH  = 4,
  parameter int               CNT_W      = 8,
  parameter int               GAIN_W     = 8,
  parameter logic [CNT_W-1:0] PERIOD_RST = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sync_a_n,
  input  logic                          sync_b_n,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_addr,
  input  logic [REG_W-1:0]              wr_data,
  output logic [N_FIXED+NUM_FLUSH-1:0]  sync_out,
  output logic [GAIN_W-1:0]             gain_out
);
  localparam int NUM_SYNC = N_FIXED + NUM_FLUSH;
  localparam int NUM_REG  = 7;
  localparam int AW       = $clog2(NUM_REG);

  logic [REG_W-1:0] cfg_q [NUM_REG];
  logic sa, sb, os_w, tc_w, tc_sel;
  logic cfg_wr, ctrl_wr, gain_wr;

  assign sa = ~sync_a_n;
  assign sb = ~sync_b_n;

  assign cfg_wr  = wr_en && (wr_addr < 4'(NUM_REG));
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign gain_wr = wr_en && (wr_addr == A_GAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_REG; a++)
        cfg_q[a] <= (a == int'(A_PERIOD)) ? REG_W'(PERIOD_RST) : cfg_rst(a);
    end else if (cfg_wr) begin
      cfg_q[wr_addr[AW-1:0]] <= wr_data;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cfg_q[0][REG_W-1:3], cfg_q[3][REG_W-1:5], cfg_q[4][REG_W-1:6]};

  oneshot_gen u_os (
    .clk(clk), .rst_n(rst_n), .wr_stb(ctrl_wr),
    .wr_level(wr_data[1]), .wr_fire(wr_data[2]),
    .hold_level(cfg_q[0][1]), .hold_bit(cfg_q[0][2]), .os(os_w)
  );

  sync_cnt #(.W(CNT_W), .RST(PERIOD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .period(cfg_q[A_PERIOD][CNT_W-1:0]),
    .sync(sync_out[1]), .tc(tc_w)
  );

  assign tc_sel = cfg_q[0][0] ? os_w : tc_w;

  for (genvar gi = 0; gi < NUM_SYNC; gi++) begin : g_fn
    localparam int AD = fld_addr(gi);
    localparam int LB = fld_lsb(gi);
    if (gi == 10 || gi == 11) begin : g_w3
      sync_sel3 u_sel (
        .mode(cfg_q[AD][LB+2:LB]), .pin_a(sa), .pin_b(sb), .os(os_w), .y(sync_out[gi])
      );
    end else begin : g_w2
      logic alt;
      if (alt_kind(gi) == ALT_ONESHOT) begin : g_os
        assign alt = os_w;
      end else if (alt_kind(gi) == ALT_PIN_B) begin : g_pb
        assign alt = sb;
      end else begin : g_tc
        assign alt = tc_sel;
      end
      sync_sel2 u_sel (
        .mode(cfg_q[AD][LB+1:LB]), .pin(on_pin_b(gi) ? sb : sa), .alt(alt), .y(sync_out[gi])
      );
    end
  end

  gain_hold #(.W(GAIN_W)) u_gain (
    .clk(clk), .rst_n(rst_n), .wr(gain_wr), .wdata(wr_data[GAIN_W-1:0]),
    .hold_mode(cfg_q[A_SER][4]), .sync(sb), .gain(gain_out)
  );
endmodule

// File: rtl/sync_matrix_chk.sv
module sync_matrix_chk #(
  parameter int NUM_SYNC = 16,
  parameter int GAIN_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_b_n,
  input logic                wr_en,
  input logic [3:0]          wr_addr,
  input logic [NUM_SYNC-1:0] sync_out,
  input logic [GAIN_W-1:0]   gain_out,
  input logic [1:0]          mode_freq,
  input logic [1:0]          mode_nco,
  input logic [1:0]          mode_cnt,
  input logic [2:0]          mode_ratio,
  input logic                os_level,
  input logic                oneshot,
  input logic                gain_sync
);
  assert_on_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_freq == 2'd3) |-> sync_out[4]);

  assert_pin_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_nco == 2'd1) |-> (sync_out[6] == !sync_b_n));

  assert_cnt_oneshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cnt == 2'd2) |-> (sync_out[1] == oneshot));

  assert_ratio_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ratio[2:1] == 2'b11) |-> sync_out[11]);

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_level && oneshot && !(wr_en && wr_addr == 4'd0)) |=> !oneshot);

  assert_gain_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sync && sync_b_n) |=> $stable(gain_out));
endmodule

bind sync_matrix sync_matrix_chk #(.NUM_SYNC(N_FIXED + NUM_FLUSH), .GAIN_W(GAIN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_b_n(sync_b_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sync_out(sync_out), .gain_out(gain_out),
  .mode_freq(cfg_q[2][1:0]), .mode_nco(cfg_q[2][5:4]), .mode_cnt(cfg_q[1][3:2]),
  .mode_ratio(cfg_q[4][5:3]), .os_level(cfg_q[0][1]), .oneshot(os_w),
  .gain_sync(cfg_q[3][4])
);

// File: tb/sync_matrix_tb_top.sv
module sync_matrix_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_a_n = 1'b1, sync_b_n = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] sync_out;
  logic [7:0] gain_out;
  int total = 0, bad = 0;
  logic [7:0] sh [0:6];

  always #5 clk = ~clk;

  sync_matrix dut_i (
    .clk(clk), .rst_n(rst_n), .sync_a_n(sync_a_n), .sync_b_n(sync_b_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_out(sync_out), .gain_out(gain_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a < 7) sh[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int f_addr(input int fn);
    if (fn < 4) return 1;
    if (fn < 8) return 2;
    if (fn < 10) return 3;
    if (fn < 12) return 4;
    return 5;
  endfunction

  function automatic int f_lsb(input int fn);
    if (fn < 10) return 2 * (fn % 4);
    if (fn == 10) return 0;
    if (fn == 11) return 3;
    return 2 * (fn - 12);
  endfunction

  task automatic set_mode(input int fn, input int mode);
    int a = f_addr(fn);
    int l = f_lsb(fn);
    int w = (fn == 10 || fn == 11) ? 3 : 2;
    logic [7:0] m = 8'(((1 << w) - 1) << l);
    logic [7:0] d = (sh[a] & ~m) | (8'(mode << l) & m);
    if (a == 1 && fn != 1) d = (d & 8'hF3) | 8'h0C; // keep counter reloading: tc stays low
    wr(4'(a), d);
  endtask

  function automatic logic exp_out(input int fn, input int mode, input logic sa, input logic sb,
                                   input logic os, input logic useos);
    if (fn == 10 || fn == 11) begin
      case (mode)
        2: return sa;
        3: return sb;
        4: return os;
        6, 7: return 1'b1;
        default: return 1'b0;
      endcase
    end
    case (mode)
      0: return 1'b0;
      1: return (fn >= 4 && fn <= 7) ? sb : sa;
      2: begin
        if (fn == 1) return os;
        if (fn == 8 || fn == 9) return sb;
        return useos ? os : 1'b0;
      end
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input int fn, input int mode);
    if (fn == 10 || fn == 11) return "R6";
    if (fn >= 12) return "R12";
    if (mode == 2) return (fn == 1) ? "R4" : ((fn == 8 || fn == 9) ? "R5" : "R3");
    if (mode == 1) return "R2";
    return "R1";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    sh[0] = 8'h00; sh[1] = 8'hA9; sh[2] = 8'h0F; sh[3] = 8'h05;
    sh[4] = 8'h1A; sh[5] = 8'h55; sh[6] = 8'h0F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset defaults seen at the strobes
    @(negedge clk); #1;
    chk(sync_out == 16'h0030, "R11 idle pins", sync_out, 16'h0030);
    chk(gain_out == 8'h00, "R11 gain", gain_out, 0);
    sync_a_n = 1'b0; #1;
    chk(sync_out == 16'hF731, "R11 pin A", sync_out, 16'hF731);
    sync_a_n = 1'b1; sync_b_n = 1'b0; #1;
    chk(sync_out == 16'h0830, "R11 pin B", sync_out, 16'h0830);
    sync_b_n = 1'b1;

    // R1..R6, R12 sweep over every strobe, mode, pin pair and one-shot setting
    wr(4'd6, 8'd20);
    for (int fn = 0; fn < 16; fn++) begin
      int nm = (fn == 10 || fn == 11) ? 8 : 4;
      for (int mode = 0; mode < nm; mode++) begin
        set_mode(fn, mode);
        for (int u = 0; u < 2; u++) begin
          for (int o = 0; o < 2; o++) begin
            wr(4'd0, 8'(4 * o + 2 + u));
            for (int p = 0; p < 4; p++) begin
              @(negedge clk);
              sync_a_n = ~p[0]; sync_b_n = ~p[1]; #1;
              chk(sync_out[fn] == exp_out(fn, mode, p[0], p[1], o[0], u[0]),
                  req_of(fn, mode), sync_out[fn],
                  exp_out(fn, mode, p[0], p[1], o[0], u[0]));
            end
            sync_a_n = 1'b1; sync_b_n = 1'b1;
          end
        end
      end
    end

    // R7: pulse form gives one cycle
    set_mode(4, 2);
    set_mode(1, 2);
    wr(4'd0, 8'h05); #1;
    chk(sync_out[4] == 1'b1, "R7 pulse high", sync_out[4], 1);
    chk(sync_out[1] == 1'b1, "R7 counter strobe pulse", sync_out[1], 1);
    @(negedge clk); #1;
    chk(sync_out[4] == 1'b0, "R7 pulse gone", sync_out[4], 0);
    @(negedge clk); #1;
    chk(sync_out[4] == 1'b0, "R7 stored bit ignored in pulse form", sync_out[4], 0);

    // R8: level form held until cleared
    wr(4'd0, 8'h07);
    for (int k = 0; k < 4; k++) begin
      #1 chk(sync_out[4] == 1'b1, "R8 level held", sync_out[4], 1);
      @(negedge clk);
    end
    wr(4'd0, 8'h03); #1;
    chk(sync_out[4] == 1'b0, "R8 level cleared", sync_out[4], 0);

    // R9: counter reload on pin A and terminal-count timing
    wr(4'd0, 8'h00);
    wr(4'd6, 8'd5);
    wr(4'd1, 8'h24);
    @(negedge clk); sync_a_n = 1'b0;
    @(negedge clk); sync_a_n = 1'b1;
    for (int k = 0; k < 14; k++) begin
      #1 chk(sync_out[2] == ((k == 5) || (k == 11)), "R9 terminal count", sync_out[2],
             (k == 5) || (k == 11));
      @(negedge clk);
    end

    // R10: gain applied at once, then held for pin B
    wr(4'd3, sh[3] & 8'hEF);
    wr(4'd8, 8'h3C); #1;
    chk(gain_out == 8'h3C, "R10 immediate", gain_out, 8'h3C);
    wr(4'd3, sh[3] | 8'h10);
    wr(4'd8, 8'hA5);
    for (int k = 0; k < 3; k++) begin
      #1 chk(gain_out == 8'h3C, "R10 held", gain_out, 8'h3C);
      @(negedge clk);
    end
    sync_b_n = 1'b0; #1;
    chk(gain_out == 8'h3C, "R10 before edge", gain_out, 8'h3C);
    @(negedge clk); sync_b_n = 1'b1; #1;
    chk(gain_out == 8'hA5, "R10 applied on pin B", gain_out, 8'hA5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule